// File: doc/BRIEF.md
# Flash Buffered-Program Command Sequencer

This block sits behind the word-wide command port of a flash device and turns a short series of host bus writes into one grouped programming operation. After a two-write unlock prefix and a buffer-load command aimed at a sector, the host states how many words follow and then writes address/data pairs. The pairs are collected in a 16-word holding buffer bound to one aligned page. A confirm command then hands the buffered words to a modelled array back end. The back end waits a fixed number of busy cycles and then stores each word.

While programming runs, or after the sequence has been broken, reads return a polling status word instead of array data. Four separate misuse cases end the load automatically. Each one lights its own bit on a cause output and raises the abort flag in the status word. The device stays aborted until the host sends a dedicated three-write reset sequence. Outside those states, reads return the contents of the array.

Top module: `fwb_sequencer`

## Requirements
- R1: After reset every array word reads as FFFFh and the abort cause output is 0000b. A read strobe presents its data on `rd_data` from the clock edge that samples it.
- R2: Entry needs three writes in order: low byte AAh at address 555h, low byte 55h at address 2AAh, then 25h at any address. That third address picks the sector, which is address bits 9 and up. The next write, at an address in that sector, holds N (0 to 15), and exactly N+1 loads follow.
- R3: The first load fixes the page (address bits 4 and up). Later loads may hit any word of that page in any order. A following write of 29h at an address in the sector starts programming. Each loaded word becomes the bitwise AND of its old array contents and the buffered value.
- R4: Every load uses up one count, including repeats of the same location. For a location written more than once, the last value written is the one programmed.
- R5: During programming, a read returns the status word: bit 7 is the complement of bit 7 of the last loaded data, bit 6 inverts on each status read, and bits 5 and 1 are 0. Writes made while busy change nothing. Once the operation ends, reads return array data.
- R6: A count value above 15 aborts the sequence and sets cause bit 0.
- R7: A count write or a load whose address lies outside the chosen sector aborts the sequence and sets cause bit 1.
- R8: A load that falls outside the page chosen by the first load aborts the sequence and sets cause bit 2.
- R9: After the final load, any write other than 29h within the sector aborts the sequence, sets cause bit 3 and programs nothing.
- R10: While aborted, reads return bit 1 = 1, bit 7 equal to the complement of bit 7 of the last loaded data, bit 6 toggling and bit 5 = 0. Any writes other than the full reset sequence leave the block aborted.
- R11: AAh at 555h, then 55h at 2AAh, then F0h at any address leaves the aborted state. The cause output is cleared and reads return array data again.
- R12: If either unlock write has the wrong data or address, the decoder returns to idle. Nothing is loaded or programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe |
| bus_addr | input | 11 | Word address for reads and writes |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data or status word |
| abort_cause | output | 4 | One-hot cause of the current abort |

## Verification
A wrong sequencer state shows up as the wrong kind of word on the next read. Array data appears where a status word is expected, or the reverse, or the abort bit is set when it should be clear. The bench catches this one cycle after the read strobe. Errors in the count or the page lock show up at the confirm write. A wrong abort or a missed abort moves `abort_cause` on the edge after the offending write. Buffer or back-end faults, such as a lost repeat-load or a missing AND, become visible only after the busy window ends. The bench catches them when it reads back all sixteen words of the page.

// File: rtl/fwb_pkg.sv
// Shared types and command constants for the buffered-program sequencer.
// Assumes word-mode addressing with command compare on the low 11 address bits.
package fwb_pkg;
    typedef enum logic [3:0] {
        ST_READ, ST_UNL1, ST_UNL2, ST_COUNT, ST_LOAD,
        ST_CONFIRM, ST_BUSY, ST_ABORT, ST_ABR1, ST_ABR2
    } seq_state_t;

    typedef enum logic [1:0] {ENG_IDLE, ENG_WAIT, ENG_WRITE} eng_phase_t;

    localparam int          CMD_AW        = 11;
    localparam logic [10:0] ADR_KEY_A     = 11'h555;
    localparam logic [10:0] ADR_KEY_B     = 11'h2AA;
    localparam logic [7:0]  KEY_A         = 8'hAA;
    localparam logic [7:0]  KEY_B         = 8'h55;
    localparam logic [7:0]  OP_BUF_LOAD   = 8'h25;
    localparam logic [7:0]  OP_CONFIRM    = 8'h29;
    localparam logic [7:0]  OP_ABORT_RST  = 8'hF0;

    localparam int ABT_COUNT   = 0;
    localparam int ABT_SECTOR  = 1;
    localparam int ABT_PAGE    = 2;
    localparam int ABT_CONFIRM = 3;
endpackage

// File: rtl/fwb_cmd_decoder.sv
// Command decoder: walks the unlock / load / count / confirm sequence,
// locks sector and page, counts loads, and flags the four abort causes.
// Assumes one write per wr_en cycle; the back end reports completion on eng_done.
module fwb_cmd_decoder
    import fwb_pkg::*;
#(
    parameter int AW     = 11,
    parameter int DW     = 16,
    parameter int SECT_W = 9,
    parameter int PAGE_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [DW-1:0]        wr_data,
    input  logic                 eng_done,
    output logic                 buf_clr,
    output logic                 buf_we,
    output logic [PAGE_W-1:0]    buf_idx,
    output logic                 prog_start,
    output logic [AW-PAGE_W-1:0] page_base,
    output logic [DW-1:0]        last_data,
    output logic [3:0]           abort_why,
    output logic                 status_mode,
    output logic                 aborted,
    output logic                 busy
);
    localparam int              SEC_N   = AW - SECT_W;
    localparam int              PG_N    = AW - PAGE_W;
    localparam int              DEPTH   = 1 << PAGE_W;
    localparam logic [DW-1:0]   MAX_CNT = DW'(DEPTH - 1);

    seq_state_t          state_q, state_d;
    logic [SEC_N-1:0]    sect_q;
    logic [PG_N-1:0]     page_q;
    logic [PAGE_W-1:0]   cnt_q;
    logic                first_q;
    logic [DW-1:0]       last_q;
    logic [3:0]          why_q;
    logic [3:0]          abort_set;
    logic                key_a, key_b, sect_ok, page_ok, cnt_take, why_clr;
    logic [7:0]          op;

    assign op      = wr_data[7:0];
    assign key_a   = (op == KEY_A) && (wr_addr[CMD_AW-1:0] == ADR_KEY_A);
    assign key_b   = (op == KEY_B) && (wr_addr[CMD_AW-1:0] == ADR_KEY_B);
    assign sect_ok = (wr_addr[AW-1:SECT_W] == sect_q);
    assign page_ok = (wr_addr[AW-1:PAGE_W] == page_q);
    assign buf_idx = wr_addr[PAGE_W-1:0];

    // Next-state decode of each bus write, with abort detection.
    always_comb begin
        state_d    = state_q;
        buf_clr    = 1'b0;
        buf_we     = 1'b0;
        prog_start = 1'b0;
        cnt_take   = 1'b0;
        why_clr    = 1'b0;
        abort_set  = '0;
        if (wr_en) begin
            case (state_q)
                ST_READ:  if (key_a) state_d = ST_UNL1;
                ST_UNL1:  state_d = key_b ? ST_UNL2 : ST_READ;
                ST_UNL2:  state_d = (op == OP_BUF_LOAD) ? ST_COUNT : ST_READ;
                ST_COUNT: begin
                    if (wr_data > MAX_CNT)  abort_set[ABT_COUNT]  = 1'b1;
                    else if (!sect_ok)      abort_set[ABT_SECTOR] = 1'b1;
                    else begin
                        state_d  = ST_LOAD;
                        buf_clr  = 1'b1;
                        cnt_take = 1'b1;
                    end
                end
                ST_LOAD: begin
                    if (!sect_ok)                 abort_set[ABT_SECTOR] = 1'b1;
                    else if (!first_q && !page_ok) abort_set[ABT_PAGE]  = 1'b1;
                    else begin
                        buf_we = 1'b1;
                        if (cnt_q == '0) state_d = ST_CONFIRM;
                    end
                end
                ST_CONFIRM: begin
                    if ((op == OP_CONFIRM) && sect_ok) begin
                        state_d    = ST_BUSY;
                        prog_start = 1'b1;
                    end else begin
                        abort_set[ABT_CONFIRM] = 1'b1;
                    end
                end
                ST_ABORT: if (key_a) state_d = ST_ABR1;
                ST_ABR1:  state_d = key_b ? ST_ABR2 : ST_ABORT;
                ST_ABR2: begin
                    if (op == OP_ABORT_RST) begin
                        state_d = ST_READ;
                        why_clr = 1'b1;
                    end else begin
                        state_d = ST_ABORT;
                    end
                end
                default: ;
            endcase
        end
        if ((state_q == ST_BUSY) && eng_done) state_d = ST_READ;
        if (|abort_set) state_d = ST_ABORT;
    end

    // State, sector/page locks, load counter, last data and abort cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_READ;
            sect_q  <= '0;
            page_q  <= '0;
            cnt_q   <= '0;
            first_q <= 1'b0;
            last_q  <= '0;
            why_q   <= '0;
        end else begin
            state_q <= state_d;
            if (wr_en && (state_q == ST_UNL2) && (op == OP_BUF_LOAD))
                sect_q <= wr_addr[AW-1:SECT_W];
            if (cnt_take) begin
                cnt_q   <= wr_data[PAGE_W-1:0];
                first_q <= 1'b1;
            end else if (buf_we) begin
                cnt_q   <= cnt_q - 1'b1;
                first_q <= 1'b0;
                last_q  <= wr_data;
                if (first_q) page_q <= wr_addr[AW-1:PAGE_W];
            end
            if (why_clr)        why_q <= '0;
            else if (|abort_set) why_q <= abort_set;
        end
    end

    assign page_base   = page_q;
    assign last_data   = last_q;
    assign abort_why   = why_q;
    assign aborted     = (state_q == ST_ABORT) || (state_q == ST_ABR1) || (state_q == ST_ABR2);
    assign busy        = (state_q == ST_BUSY);
    assign status_mode = aborted || busy;

    AST_ABORT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        aborted |-> (why_q != 4'b0000)) else $error("abort without cause"); // R10
    AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(why_q)) else $error("abort cause not one-hot"); // R6
    AST_READ_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ) |-> (why_q == 4'b0000)) else $error("cause left set"); // R11
endmodule

// File: rtl/fwb_load_buffer.sv
// Holding buffer: one word per page location plus a loaded mask.
// Assumes clear and load never coincide; a repeat load overwrites the word.
module fwb_load_buffer #(
    parameter int DW     = 16,
    parameter int PAGE_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          we,
    input  logic [PAGE_W-1:0]             idx,
    input  logic [DW-1:0]                 din,
    output logic [(1<<PAGE_W)-1:0][DW-1:0] words,
    output logic [(1<<PAGE_W)-1:0]        loaded
);
    localparam int DEPTH = 1 << PAGE_W;

    // One register per location; load mask cleared at sequence start.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[g]  <= '0;
                loaded[g] <= 1'b0;
            end else if (clr) begin
                loaded[g] <= 1'b0;
            end else if (we && (idx == PAGE_W'(g))) begin
                words[g]  <= din;
                loaded[g] <= 1'b1;
            end
        end
    end

    AST_CLR_LOAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr && we)) else $error("clear and load together"); // R4
endmodule

// File: rtl/fwb_array.sv
// Array back end: word memory erased to all ones, plus a program engine
// that waits PROG_CYCLES and then ANDs each loaded buffer word into the page.
// Assumes start arrives only while idle and the buffer is stable while busy.
module fwb_array
    import fwb_pkg::*;
#(
    parameter int AW          = 11,
    parameter int DW          = 16,
    parameter int PAGE_W      = 4,
    parameter int PROG_CYCLES = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [AW-1:0]                  rd_addr,
    output logic [DW-1:0]                  rd_q,
    input  logic                           start,
    input  logic [AW-PAGE_W-1:0]           page_base,
    input  logic [(1<<PAGE_W)-1:0][DW-1:0] words,
    input  logic [(1<<PAGE_W)-1:0]         loaded,
    output logic                           eng_busy,
    output logic                           eng_done
);
    localparam int WORDS  = 1 << AW;
    localparam int DEPTH  = 1 << PAGE_W;
    localparam int WAIT_W = $clog2(PROG_CYCLES + 1);

    logic [DW-1:0]     mem [WORDS];
    eng_phase_t        phase_q;
    logic [WAIT_W-1:0] wait_q;
    logic [PAGE_W-1:0] idx_q;
    logic              wr_slot;

    assign rd_q     = mem[rd_addr];
    assign eng_busy = (phase_q != ENG_IDLE);
    assign eng_done = (phase_q == ENG_WRITE) && (idx_q == PAGE_W'(DEPTH - 1));
    assign wr_slot  = (phase_q == ENG_WRITE) && loaded[idx_q];

    // Program engine sequencing: busy delay, then one slot per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= ENG_IDLE;
            wait_q  <= '0;
            idx_q   <= '0;
        end else begin
            case (phase_q)
                ENG_IDLE: if (start) begin
                    phase_q <= ENG_WAIT;
                    wait_q  <= WAIT_W'(PROG_CYCLES - 1);
                end
                ENG_WAIT: begin
                    if (wait_q == '0) begin
                        phase_q <= ENG_WRITE;
                        idx_q   <= '0;
                    end else begin
                        wait_q <= wait_q - 1'b1;
                    end
                end
                ENG_WRITE: begin
                    if (eng_done) phase_q <= ENG_IDLE;
                    idx_q <= idx_q + 1'b1;
                end
                default: phase_q <= ENG_IDLE;
            endcase
        end
    end

    // Memory: erased on reset, bits only cleared by programming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        end else if (wr_slot) begin
            mem[{page_base, idx_q}] <= mem[{page_base, idx_q}] & words[idx_q];
        end
    end

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (phase_q == ENG_IDLE)) else $error("start while busy"); // R5
    AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> eng_busy) else $error("start ignored"); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> !eng_done) else $error("done held"); // R5
endmodule

// File: rtl/fwb_sequencer.sv
// Top: ties decoder, holding buffer and array back end together and forms
// the registered read path (array data, or status word while busy/aborted).
// Assumes AW >= 11 so the command addresses fit the address bus.
module fwb_sequencer
    import fwb_pkg::*;
#(
    parameter int AW          = 11,
    parameter int DW          = 16,
    parameter int SECT_W      = 9,
    parameter int PAGE_W      = 4,
    parameter int PROG_CYCLES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic [3:0]    abort_cause
);
    localparam int DEPTH = 1 << PAGE_W;

    logic                     buf_clr, buf_we, prog_start;
    logic [PAGE_W-1:0]        buf_idx;
    logic [AW-PAGE_W-1:0]     page_base;
    logic [DW-1:0]            last_data, arr_q, stat_word;
    logic                     status_mode, aborted, dec_busy;
    logic                     eng_busy, eng_done, tog_q;
    logic [DEPTH-1:0][DW-1:0] words;
    logic [DEPTH-1:0]         loaded;

    fwb_cmd_decoder #(.AW(AW), .DW(DW), .SECT_W(SECT_W), .PAGE_W(PAGE_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(bus_addr),
        .wr_data(wr_data), .eng_done(eng_done), .buf_clr(buf_clr),
        .buf_we(buf_we), .buf_idx(buf_idx), .prog_start(prog_start),
        .page_base(page_base), .last_data(last_data), .abort_why(abort_cause),
        .status_mode(status_mode), .aborted(aborted), .busy(dec_busy)
    );

    fwb_load_buffer #(.DW(DW), .PAGE_W(PAGE_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we),
        .idx(buf_idx), .din(wr_data), .words(words), .loaded(loaded)
    );

    fwb_array #(.AW(AW), .DW(DW), .PAGE_W(PAGE_W), .PROG_CYCLES(PROG_CYCLES)) u_arr (
        .clk(clk), .rst_n(rst_n), .rd_addr(bus_addr), .rd_q(arr_q),
        .start(prog_start), .page_base(page_base), .words(words),
        .loaded(loaded), .eng_busy(eng_busy), .eng_done(eng_done)
    );

    // Status word: inverted data bit 7, toggle bit 6, abort flag bit 1.
    always_comb begin
        stat_word    = '0;
        stat_word[7] = ~last_data[7];
        stat_word[6] = tog_q;
        stat_word[1] = aborted;
    end

    // Registered read port; the toggle advances on every status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            tog_q   <= 1'b0;
        end else if (rd_en) begin
            if (status_mode) begin
                rd_data <= stat_word;
                tog_q   <= ~tog_q;
            end else begin
                rd_data <= arr_q;
            end
        end
    end

    AST_BUSY_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        dec_busy |-> eng_busy) else $error("decoder busy, engine idle"); // R5
    AST_ENGINE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> dec_busy) else $error("engine runs outside busy"); // R3
endmodule

// File: tb/fwb_sequencer_bench.sv
module fwb_sequencer_bench;
    localparam int AW = 11;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic [3:0]    abort_cause;

    int            n_chk = 0;
    int            n_fail = 0;
    logic [15:0]   mdl [2048];
    logic [15:0]   last_ld = 16'h0000;

    always #2.5 clk = ~clk;

    fwb_sequencer u_fwb_sequencer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .bus_addr(bus_addr), .wr_data(wr_data), .rd_data(rd_data),
        .abort_cause(abort_cause)
    );

    function automatic void chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endfunction

    // Expected status word with bit 6 masked out.
    function automatic logic [15:0] stat_exp(logic ab);
        return {8'h00, ~last_ld[7], 5'b00000, ab, 1'b0};
    endfunction

    function automatic int sec_base(int s);
        return s << 9;
    endfunction

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; bus_addr = AW'(a); wr_data = DW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] q);
        @(negedge clk);
        rd_en = 1'b1; bus_addr = AW'(a);
        @(negedge clk);
        q = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic unlock(input int cmd, input int a);
        wr(12'h555, 8'hAA);
        wr(12'h2AA, 8'h55);
        wr(a, cmd);
    endtask

    // Two status reads: masked value and toggle of bit 6.
    task automatic stat_pair(string tag, input logic ab);
        logic [15:0] q1, q2;
        rd(0, q1);
        rd(0, q2);
        chk(tag, q1 & 16'hFFBF, stat_exp(ab));
        chk({tag, " toggle"}, 16'(q1[6] ^ q2[6]), 16'h0001);
    endtask

    task automatic page_check(string tag, input int pbase);
        logic [15:0] q;
        for (int i = 0; i < 16; i++) begin
            rd(pbase + i, q);
            chk(tag, q, mdl[pbase + i]);
        end
    endtask

    task automatic abort_reset();
        unlock(8'hF0, 12'h123);
    endtask

    // Full buffered program: count cnt, offsets/data given, then confirm.
    task automatic do_prog(input int s, input int pg, input int cnt,
                           input logic [3:0] offs [16], input logic [15:0] dat [16]);
        logic [15:0] bufd [16];
        logic        bufv [16];
        int          pbase;
        pbase = sec_base(s) + (pg << 4);
        for (int i = 0; i < 16; i++) bufv[i] = 1'b0;
        unlock(8'h25, sec_base(s) + 7);
        wr(sec_base(s) + 3, cnt);
        for (int i = 0; i <= cnt; i++) begin
            wr(pbase + offs[i], dat[i]);
            bufd[offs[i]] = dat[i];
            bufv[offs[i]] = 1'b1;
            last_ld = dat[i];
        end
        wr(sec_base(s) + 1, 8'h29);
        stat_pair("R5 busy status", 1'b0);
        wr(pbase + offs[0], 16'h0000);          // R5: write while busy ignored
        repeat (40) @(negedge clk);
        for (int i = 0; i < 16; i++)
            if (bufv[i]) mdl[pbase + i] = mdl[pbase + i] & bufd[i];
        chk("R2 R3 no abort after program", 16'(abort_cause), 16'h0000);
        page_check("R3 R4 programmed page", pbase);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] q;
        logic [3:0]  offs [16];
        logic [15:0] dat [16];
        void'($urandom(32'd4242));
        for (int i = 0; i < 2048; i++) mdl[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(12'h0A5, q);  chk("R1 erased read", q, 16'hFFFF);
        rd(12'h7FF, q);  chk("R1 erased read top", q, 16'hFFFF);
        chk("R1 cause clear", 16'(abort_cause), 16'h0000);

        // R4: repeated location, count consumed per load; last data wins
        offs[0] = 4'd5; dat[0] = 16'h1234;
        offs[1] = 4'd5; dat[1] = 16'hA5C3;
        offs[2] = 4'd6; dat[2] = 16'h0F0F;
        do_prog(1, 3, 2, offs, dat);
        rd(sec_base(1) + (3 << 4) + 5, q);
        chk("R4 last data wins", q, 16'hA5C3);

        // R3: AND with existing contents on a second pass
        offs[0] = 4'd5; dat[0] = 16'hFF00;
        do_prog(1, 3, 0, offs, dat);
        rd(sec_base(1) + (3 << 4) + 5, q);
        chk("R3 AND with old data", q, 16'hA500);

        // Random programs over all sectors and pages
        for (int r = 0; r < 8; r++) begin
            int s, pg, cnt;
            s = int'($urandom % 4); pg = int'($urandom % 32); cnt = int'($urandom % 16);
            for (int i = 0; i < 16; i++) begin
                offs[i] = 4'($urandom);
                dat[i]  = 16'($urandom);
            end
            do_prog(s, pg, cnt, offs, dat);
        end

        // R6: count too large
        unlock(8'h25, sec_base(2));
        wr(sec_base(2), 16);
        chk("R6 cause bit0", 16'(abort_cause), 16'h0001);
        stat_pair("R10 abort status", 1'b1);
        wr(sec_base(2), 8'h29);
        wr(12'h100, 8'hF0);
        stat_pair("R10 stray writes keep abort", 1'b1);
        abort_reset();
        chk("R11 cause cleared", 16'(abort_cause), 16'h0000);
        rd(sec_base(1) + (3 << 4) + 5, q);
        chk("R11 array read after reset", q, mdl[sec_base(1) + (3 << 4) + 5]);

        // R7: load into a different sector
        unlock(8'h25, sec_base(0));
        wr(sec_base(0), 3);
        wr(sec_base(0) + 16, 16'h00FF); last_ld = 16'h00FF;
        wr(sec_base(3) + 16, 16'h0000);
        chk("R7 cause bit1", 16'(abort_cause), 16'h0002);
        stat_pair("R10 status after sector abort", 1'b1);
        abort_reset();
        page_check("R7 nothing programmed", sec_base(0) + 16);

        // R7: count written outside the sector
        unlock(8'h25, sec_base(0));
        wr(sec_base(1), 2);
        chk("R7 count wrong sector bit1", 16'(abort_cause), 16'h0002);
        abort_reset();

        // R8: load into a different page
        unlock(8'h25, sec_base(2));
        wr(sec_base(2), 4);
        wr(sec_base(2) + 32 + 1, 16'h7F00); last_ld = 16'h7F00;
        wr(sec_base(2) + 48 + 1, 16'h0000);
        chk("R8 cause bit2", 16'(abort_cause), 16'h0004);
        stat_pair("R10 status after page abort", 1'b1);
        abort_reset();
        page_check("R8 nothing programmed", sec_base(2) + 32);

        // R9: wrong confirm after final load
        unlock(8'h25, sec_base(3));
        wr(sec_base(3), 0);
        wr(sec_base(3) + 64 + 2, 16'h0000); last_ld = 16'h0000;
        wr(sec_base(3), 8'h30);
        chk("R9 cause bit3", 16'(abort_cause), 16'h0008);
        abort_reset();
        page_check("R9 nothing programmed", sec_base(3) + 64);

        // R9: confirm at wrong sector
        unlock(8'h25, sec_base(3));
        wr(sec_base(3), 0);
        wr(sec_base(3) + 64 + 2, 16'h0000);
        wr(sec_base(0), 8'h29);
        chk("R9 confirm other sector bit3", 16'(abort_cause), 16'h0008);
        abort_reset();

        // R11: incomplete reset sequence keeps abort
        unlock(8'h25, sec_base(2));
        wr(sec_base(2), 16'h0100);
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h000, 8'hF1);
        chk("R11 wrong reset data keeps cause", 16'(abort_cause), 16'h0001);
        abort_reset();
        chk("R11 reset clears cause", 16'(abort_cause), 16'h0000);

        // R12: bad unlock returns to idle, later writes ignored
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h56);
        wr(sec_base(3) + 80, 8'h25); wr(sec_base(3) + 80, 0);
        wr(sec_base(3) + 80, 16'h0000); wr(sec_base(3) + 80, 8'h29);
        repeat (40) @(negedge clk);
        rd(sec_base(3) + 80, q);
        chk("R12 bad unlock data no effect", q, mdl[sec_base(3) + 80]);
        wr(12'h554, 8'hAA); wr(12'h2AA, 8'h55); wr(sec_base(3) + 80, 8'h25);
        wr(sec_base(3) + 80, 0); wr(sec_base(3) + 80, 16'h0000);
        chk("R12 bad unlock addr no abort", 16'(abort_cause), 16'h0000);
        rd(sec_base(3) + 80, q);
        chk("R12 bad unlock addr array read", q, mdl[sec_base(3) + 80]);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule